// File: doc/BRIEF.md
# Pipeline Interlock Stall Unit

This block detects read-after-write hazards in a four-stage in-order pipeline (fetch, register read, ALU, write-back) that has no operand forwarding. The register file is read combinationally in the register-read stage and written only on the clock edge that closes write-back. A consumer therefore cannot take an operand until its producer has left write-back. When the instruction in register read needs a register that an older instruction in ALU or write-back will still write, the unit freezes the fetch and register-read stage registers. For each stall cycle it also tells the datapath to load a NOP into the ALU-stage instruction register.

The unit takes only the decoded fields of the instruction in register read. It keeps its own shadow copy of the destination information for the stages downstream of register read. That copy advances as the pipeline does and receives a non-writing slot on every injected NOP. The depth of this shadow chain is a parameter, so the same block serves pipelines that have more stages between operand read and register write. The datapath itself lies outside this block.

Top module: `pipe_interlock`

## Requirements
- R1: After reset the ALU and write-back slots hold no pending writes, so no freeze and no NOP injection occur whatever the register-read inputs are, until an instruction has advanced.
- R2: An instruction that reads a register written by the instruction directly ahead of it is held for exactly two cycles.
- R3: An instruction that reads a register written by the instruction two ahead of it (now in write-back) is held for exactly one cycle.
- R4: A dependency on an instruction three or more ahead causes no stall, because that write has already reached the register file.
- R5: `hold_fetch`, `hold_rr` and `inject_nop` are asserted together in every stall cycle, which gives one NOP per stall cycle.
- R6: Register 31 reads as zero. A source field of 31 never stalls, and a write aimed at register 31 never creates a hazard.
- R7: `rr_kind` selects the compared operands. 2'b00 reads no register, 2'b01 reads only the A source, and 2'b10 and 2'b11 read both the A and B sources. A B-source match under 2'b01 causes no stall.
- R8: Injected NOP slots carry no write. Once a stall resolves, a later instruction that reads only the original producer's register is not stalled.
- R9: With `rr_valid` low there is no stall, and that empty slot creates no hazard for the instruction after it, whatever its `rr_wr` and `rr_rc` fields are.
- R10: An instruction whose `rr_wr` is low (store or branch) creates no hazard for later readers of its `rr_rc` register.
- R11: Driving a pipeline model with this unit's controls gives the same final register values as executing the same program one instruction at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_valid | input | 1 | Register-read stage holds a real instruction |
| rr_kind | input | 2 | Operand class: 00 none, 01 A only, 10/11 A and B |
| rr_ra | input | REG_W | A source register number |
| rr_rb | input | REG_W | B source register number |
| rr_wr | input | 1 | Instruction writes its destination register |
| rr_rc | input | REG_W | Destination register number |
| hold_fetch | output | 1 | Freeze the fetch stage register |
| hold_rr | output | 1 | Freeze the register-read stage register |
| inject_nop | output | 1 | Load a NOP into the ALU-stage instruction register |

## Verification
The checker watches several properties on every cycle. It confirms that an empty slot or an instruction without source operands never stalls, and that an A-only read of register 31 never stalls. It confirms that a reader directly behind a real writer of its A source is held. A counter bounds every run of consecutive stall cycles at the shadow depth. The exact stall lengths for each producer distance and the quiet state after reset are shown by the bench's scenarios. So are the effect of write-disabled and invalid slots and the end-to-end register values from a pipelined run, because these depend on whole instruction sequences.

// File: rtl/il_pkg.sv
package il_pkg;

   typedef enum logic [1:0] {
      SRC_NONE   = 2'b00,
      SRC_A      = 2'b01,
      SRC_AB     = 2'b10,
      SRC_AB_ALT = 2'b11
   } src_kind_e;

   function automatic logic kind_reads_a(input logic [1:0] k);
      return (src_kind_e'(k) != SRC_NONE);
   endfunction

   function automatic logic kind_reads_b(input logic [1:0] k);
      return (src_kind_e'(k) == SRC_AB) || (src_kind_e'(k) == SRC_AB_ALT);
   endfunction

endpackage

// File: rtl/il_dst_pipe.sv
module il_dst_pipe #(
   parameter int REG_W = 5,
   parameter int DEPTH = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_wr,
   input  logic [REG_W-1:0]            in_rc,
   input  logic                        kill,
   output logic [DEPTH-1:0]            st_wr,
   output logic [DEPTH-1:0][REG_W-1:0] st_rc
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("il_dst_pipe: DEPTH must be at least 1");
   end

   for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      if (k == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n || kill) begin
               st_wr[0] <= 1'b0;
               st_rc[0] <= '0;
            end else begin
               st_wr[0] <= in_wr;
               st_rc[0] <= in_rc;
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               st_wr[k] <= 1'b0;
               st_rc[k] <= '0;
            end else begin
               st_wr[k] <= st_wr[k-1];
               st_rc[k] <= st_rc[k-1];
            end
         end
      end
   end

endmodule

// File: rtl/il_src_cmp.sv
module il_src_cmp #(
   parameter int REG_W    = 5,
   parameter int DEPTH    = 2,
   parameter bit HAS_ZERO = 1'b1,
   parameter int ZERO_REG = 31
) (
   input  logic                        use_src,
   input  logic [REG_W-1:0]            src,
   input  logic [DEPTH-1:0]            st_wr,
   input  logic [DEPTH-1:0][REG_W-1:0] st_rc,
   output logic                        hit
);

   localparam logic [REG_W-1:0] ZR = REG_W'(ZERO_REG);

   logic [DEPTH-1:0] stage_match;
   logic             src_live;

   for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
      assign stage_match[k] = st_wr[k] && (st_rc[k] == src);
   end

   if (HAS_ZERO) begin : g_zero
      assign src_live = use_src && (src != ZR);
   end else begin : g_nozero
      assign src_live = use_src;
   end

   assign hit = src_live && (|stage_match);

endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
   import il_pkg::*;
#(
   parameter int REG_W    = 5,
   parameter int WB_DEPTH = 2,
   parameter bit HAS_ZERO = 1'b1,
   parameter int ZERO_REG = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rr_valid,
   input  logic [1:0]       rr_kind,
   input  logic [REG_W-1:0] rr_ra,
   input  logic [REG_W-1:0] rr_rb,
   input  logic             rr_wr,
   input  logic [REG_W-1:0] rr_rc,
   output logic             hold_fetch,
   output logic             hold_rr,
   output logic             inject_nop
);

   localparam int               N_SRC = 2;
   localparam logic [REG_W-1:0] ZR    = REG_W'(ZERO_REG);

   if (REG_W < 1) begin : g_bad_w
      $error("pipe_interlock: REG_W must be positive");
   end
   if (WB_DEPTH < 1) begin : g_bad_d
      $error("pipe_interlock: WB_DEPTH must be at least 1");
   end
   if (HAS_ZERO && (ZERO_REG >= (1 << REG_W) || ZERO_REG < 0)) begin : g_bad_z
      $error("pipe_interlock: ZERO_REG out of range");
   end

   logic [WB_DEPTH-1:0]            st_wr;
   logic [WB_DEPTH-1:0][REG_W-1:0] st_rc;
   logic [N_SRC-1:0]               src_use;
   logic [N_SRC-1:0][REG_W-1:0]    src_num;
   logic [N_SRC-1:0]               src_hit;
   logic                           stall;
   logic                           new_wr;

   always_comb begin
      src_use[0] = rr_valid && kind_reads_a(rr_kind);
      src_use[1] = rr_valid && kind_reads_b(rr_kind);
      src_num[0] = rr_ra;
      src_num[1] = rr_rb;
   end

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      il_src_cmp #(
         .REG_W   (REG_W),
         .DEPTH   (WB_DEPTH),
         .HAS_ZERO(HAS_ZERO),
         .ZERO_REG(ZERO_REG)
      ) u_cmp (
         .use_src(src_use[s]),
         .src    (src_num[s]),
         .st_wr  (st_wr),
         .st_rc  (st_rc),
         .hit    (src_hit[s])
      );
   end

   assign stall = |src_hit;

   if (HAS_ZERO) begin : g_wr_zero
      assign new_wr = rr_valid && rr_wr && (rr_rc != ZR);
   end else begin : g_wr_plain
      assign new_wr = rr_valid && rr_wr;
   end

   il_dst_pipe #(
      .REG_W(REG_W),
      .DEPTH(WB_DEPTH)
   ) u_dst (
      .clk  (clk),
      .rst_n(rst_n),
      .in_wr(new_wr),
      .in_rc(rr_rc),
      .kill (stall),
      .st_wr(st_wr),
      .st_rc(st_rc)
   );

   assign hold_fetch = stall;
   assign hold_rr    = stall;
   assign inject_nop = stall;

endmodule

// File: rtl/il_chk.sv
module il_chk
   import il_pkg::*;
#(
   parameter int REG_W    = 5,
   parameter int WB_DEPTH = 2,
   parameter int ZERO_REG = 31
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rr_valid,
   input logic [1:0]       rr_kind,
   input logic [REG_W-1:0] rr_ra,
   input logic             rr_wr,
   input logic [REG_W-1:0] rr_rc,
   input logic             hold_rr
);

   localparam int               CW = $clog2(WB_DEPTH + 2);
   localparam logic [REG_W-1:0] ZR = REG_W'(ZERO_REG);

   logic [CW-1:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n)       run_len <= '0;
      else if (hold_rr) run_len <= run_len + 1'b1;
      else              run_len <= '0;
   end

   AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      !rr_valid |-> !hold_rr); // R9

   AST_NO_SOURCE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (src_kind_e'(rr_kind) == SRC_NONE) |-> !hold_rr); // R7

   AST_ZERO_SRC_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (src_kind_e'(rr_kind) == SRC_A && rr_ra == ZR) |-> !hold_rr); // R6

   AST_ADJACENT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && rr_valid && src_kind_e'(rr_kind) != SRC_NONE
       && $past(rr_valid && !hold_rr && rr_wr && rr_rc != ZR)
       && rr_ra == $past(rr_rc)) |-> hold_rr); // R2

   AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= CW'(WB_DEPTH)); // R4

endmodule

bind pipe_interlock il_chk #(
   .REG_W   (REG_W),
   .WB_DEPTH(WB_DEPTH),
   .ZERO_REG(ZERO_REG)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rr_valid(rr_valid),
   .rr_kind (rr_kind),
   .rr_ra   (rr_ra),
   .rr_wr   (rr_wr),
   .rr_rc   (rr_rc),
   .hold_rr (hold_rr)
);

// File: tb/sim_pipe_interlock.sv
module sim_pipe_interlock;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rr_valid = 1'b0;
   logic [1:0] rr_kind = 2'b00;
   logic [4:0] rr_ra = '0, rr_rb = '0, rr_rc = '0;
   logic       rr_wr = 1'b0;
   logic [7:0] tb_imm = '0;
   logic       hold_fetch, hold_rr, inject_nop;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;
   bit r5_bad = 1'b0;

   always #5 clk = ~clk;

   pipe_interlock u0 (
      .clk(clk), .rst_n(rst_n), .rr_valid(rr_valid), .rr_kind(rr_kind),
      .rr_ra(rr_ra), .rr_rb(rr_rb), .rr_wr(rr_wr), .rr_rc(rr_rc),
      .hold_fetch(hold_fetch), .hold_rr(hold_rr), .inject_nop(inject_nop)
   );

   // Datapath model: register file read in RR, written at the end of WB.
   logic [31:0] mrf [0:31];
   logic        a_wr, w_wr;
   logic [4:0]  a_rc, w_rc;
   logic [31:0] a_val, w_val;

   function automatic logic [31:0] rdv(input logic [4:0] r);
      return (r == 5'd31) ? 32'd0 : mrf[r];
   endfunction

   function automatic logic [31:0] op_val(input logic [1:0] k, input logic [4:0] ra,
                                          input logic [4:0] rb, input logic [7:0] imm);
      if (k == 2'b00)      return 32'd0;
      else if (k == 2'b01) return rdv(ra) + {24'd0, imm};
      else                 return rdv(ra) + rdv(rb);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) mrf[i] <= '0;
         a_wr <= 1'b0; w_wr <= 1'b0; a_rc <= '0; w_rc <= '0;
         a_val <= '0; w_val <= '0;
      end else begin
         if (w_wr && w_rc != 5'd31) mrf[w_rc] <= w_val;
         w_wr <= a_wr; w_rc <= a_rc; w_val <= a_val;
         if (hold_rr || !rr_valid) begin
            a_wr <= 1'b0; a_rc <= '0; a_val <= '0;
         end else begin
            a_wr <= rr_wr; a_rc <= rr_rc;
            a_val <= op_val(rr_kind, rr_ra, rr_rb, tb_imm);
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // Present one instruction in RR; return the number of stall cycles it sees.
   task automatic issue(input bit v, input logic [1:0] k, input logic [4:0] ra,
                        input logic [4:0] rb, input bit wr, input logic [4:0] rc,
                        input logic [7:0] imm, output int stalls);
      stalls = 0;
      @(negedge clk);
      rr_valid = v; rr_kind = k; rr_ra = ra; rr_rb = rb;
      rr_wr = wr; rr_rc = rc; tb_imm = imm;
      #1;
      while (hold_rr) begin
         if (hold_fetch !== hold_rr || inject_nop !== hold_rr) r5_bad = 1'b1;
         stalls++;
         @(negedge clk);
         #1;
      end
      if (hold_fetch !== hold_rr || inject_nop !== hold_rr) r5_bad = 1'b1;
   endtask

   task automatic filler(input int n);
      int s;
      for (int i = 0; i < n; i++) issue(1'b1, 2'b00, 5'd0, 5'd0, 1'b0, 5'd0, 8'd0, s);
   endtask

   // {p_rc[5], p_wr, gap[2], kind[2], ra[5], rb[5], exp[2]}
   localparam int NC = 9;
   localparam logic [21:0] CASES [0:NC-1] = '{
      {5'd3,  1'b1, 2'd0, 2'b10, 5'd3,  5'd1,  2'd2},  // R2
      {5'd3,  1'b1, 2'd1, 2'b01, 5'd3,  5'd0,  2'd1},  // R3
      {5'd3,  1'b1, 2'd2, 2'b10, 5'd1,  5'd3,  2'd0},  // R4
      {5'd4,  1'b1, 2'd0, 2'b01, 5'd1,  5'd4,  2'd0},  // R7 B ignored
      {5'd4,  1'b1, 2'd0, 2'b10, 5'd1,  5'd4,  2'd2},  // R7 B compared
      {5'd31, 1'b1, 2'd0, 2'b10, 5'd31, 5'd31, 2'd0},  // R6
      {5'd6,  1'b0, 2'd0, 2'b10, 5'd6,  5'd6,  2'd0},  // R10
      {5'd7,  1'b1, 2'd0, 2'b00, 5'd7,  5'd7,  2'd0},  // R7 no sources
      {5'd8,  1'b1, 2'd1, 2'b11, 5'd2,  5'd8,  2'd1}   // R7 alt code, R3
   };

   // {kind[2], ra[5], rb[5], wr, rc[5], imm[8]}
   localparam int NP = 10;
   localparam logic [25:0] PROG [0:NP-1] = '{
      {2'b01, 5'd31, 5'd0,  1'b1, 5'd1,  8'd5},
      {2'b01, 5'd1,  5'd0,  1'b1, 5'd2,  8'd3},
      {2'b10, 5'd1,  5'd2,  1'b1, 5'd3,  8'd0},
      {2'b01, 5'd31, 5'd0,  1'b1, 5'd4,  8'd7},
      {2'b10, 5'd3,  5'd4,  1'b1, 5'd5,  8'd0},
      {2'b00, 5'd5,  5'd5,  1'b0, 5'd5,  8'd0},
      {2'b11, 5'd5,  5'd5,  1'b1, 5'd1,  8'd0},
      {2'b01, 5'd1,  5'd0,  1'b1, 5'd31, 8'd1},
      {2'b10, 5'd31, 5'd1,  1'b1, 5'd6,  8'd0},
      {2'b01, 5'd6,  5'd0,  1'b1, 5'd7,  8'd9}
   };

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int s;
      logic [31:0] ref_rf [0:31];
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: quiet right after reset, even with a reading instruction present
      rr_valid = 1'b1; rr_kind = 2'b10; rr_ra = 5'd0; rr_rb = 5'd0;
      #1;
      check(!hold_rr && !hold_fetch && !inject_nop, "R1", hold_rr, 0);
      rr_valid = 1'b0;

      // table walk
      for (int c = 0; c < NC; c++) begin
         logic [21:0] e;
         e = CASES[c];
         filler(3);
         r5_bad = 1'b0;
         issue(1'b1, 2'b01, 5'd31, 5'd0, e[16], e[21:17], 8'd1, s);
         filler(int'(e[15:14]));
         issue(1'b1, e[13:12], e[11:7], e[6:2], 1'b0, 5'd0, 8'd0, s);
         check(s == int'(e[1:0]), $sformatf("R2/R3/R4/R6/R7/R10 case %0d", c), s, int'(e[1:0]));
         check(!r5_bad, "R5", r5_bad, 0);
      end

      // R9: invalid slot neither stalls nor creates a hazard
      filler(3);
      issue(1'b1, 2'b01, 5'd31, 5'd0, 1'b1, 5'd9, 8'd1, s);
      issue(1'b0, 2'b10, 5'd9, 5'd9, 1'b1, 5'd10, 8'd0, s);
      check(s == 0, "R9 invalid slot stall", s, 0);
      issue(1'b1, 2'b01, 5'd10, 5'd0, 1'b0, 5'd0, 8'd0, s);
      check(s == 0, "R9 invalid slot hazard", s, 0);

      // R8: NOP slots carry no write
      filler(3);
      issue(1'b1, 2'b01, 5'd31, 5'd0, 1'b1, 5'd11, 8'd1, s);
      issue(1'b1, 2'b01, 5'd11, 5'd0, 1'b1, 5'd12, 8'd1, s);
      check(s == 2, "R8 first consumer", s, 2);
      issue(1'b1, 2'b01, 5'd11, 5'd0, 1'b0, 5'd0, 8'd0, s);
      check(s == 0, "R8 after bubbles", s, 0);

      // R11: end-to-end program vs sequential execution
      filler(3);
      @(negedge clk);
      rst_n = 1'b0;
      rr_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 32; i++) ref_rf[i] = '0;
      for (int i = 0; i < NP; i++) begin
         logic [25:0] p;
         logic [31:0] va, vb;
         p = PROG[i];
         va = (p[23:19] == 5'd31) ? 32'd0 : ref_rf[p[23:19]];
         vb = (p[18:14] == 5'd31) ? 32'd0 : ref_rf[p[18:14]];
         if (p[13] && p[12:8] != 5'd31) begin
            if (p[25:24] == 2'b01)      ref_rf[p[12:8]] = va + {24'd0, p[7:0]};
            else if (p[25:24] != 2'b00) ref_rf[p[12:8]] = va + vb;
            else                        ref_rf[p[12:8]] = 32'd0;
         end
         issue(1'b1, p[25:24], p[23:19], p[18:14], p[13], p[12:8], p[7:0], s);
      end
      filler(4);
      for (int r = 1; r < 8; r++)
         check(mrf[r] == ref_rf[r], $sformatf("R11 reg %0d", r), int'(mrf[r]), int'(ref_rf[r]));
      check(mrf[7] == 32'd49, "R11 final value", int'(mrf[7]), 49);
      finish_run();
   end

endmodule